// File: doc/BRIEF.md
# NAND Flash Operation Trigger Engine

This block runs one NAND flash bus operation at a time. Software loads a command byte, an address byte and a buffer index through a small 16-bit register port. It then writes a one-hot start code into the operation control register. The engine drives a simplified flash pin set (command latch, address latch, write and read strobes, chip enable, an 8-bit data bus in each direction, and the ready/busy return). When the operation is over it sets a sticky done flag, and it can raise an interrupt.

Page data moves between the flash and one of four internal 512-byte buffers. Software reaches these buffers through a pointer register and a data window register. An ID read and a status read also deposit their bytes at the start of the selected buffer. The ready/busy line is handled inside the engine, so software only polls the done flag or waits for the interrupt.

Register map (3-bit address): 0 command byte, 1 address byte, 2 buffer select, 3 operation control, 4 configuration, 5 buffer pointer, 6 buffer data window.

Top module: `nand_op_engine`

## Requirements
- R1: Writing operation control (address 3) with exactly one of bits [5:0] set starts an operation. The codes are 0x01 command cycle, 0x02 address cycle, 0x04 data input (buffer to flash), 0x08 page data output (flash to buffer), 0x10 ID read and 0x20 status read. Any other value of bits [5:0] starts nothing.
- R2: Bit 15 of operation control reads 1 once the started operation completes, and stays 1 until a write to address 3 with bit 15 clear. Bits [14:0] always read 0, so start bits read back as zero.
- R3: The irq output is high exactly while the done flag is set and configuration bit 4 (interrupt mask) is clear.
- R4: A command cycle drives CLE high with the command byte (address 0) on the data bus for one WE# low pulse. An address cycle does the same with ALE and the address byte (address 1). Each WE# low pulse lasts STROBE_CLKS clocks (2 by default, 10 ns at 200 MHz).
- R5: A page data output issues 512 RE# strobes. It stores the bytes at offsets 0 to 511 of the buffer chosen by buffer select (address 2, index 0 to 3), in the order they are read.
- R6: A data input issues 512 WE# strobes. It drives offsets 0 to 511 of the selected buffer onto the data bus in order, with CLE and ALE low.
- R7: Data input and page data output give no strobe while R/B# is low at the start. Neither sets the done flag while R/B# is low after the last strobe.
- R8: With configuration bit 2 (spare-only) set, data input and page data output move 16 bytes, at buffer offsets 0 to 15.
- R9: An ID read stores 5 bytes at offsets 0 to 4 of the selected buffer. A status read stores one byte at offset 0. Every other buffer byte is left unchanged.
- R10: A start code written while an operation is in progress is ignored. The running operation finishes unchanged and no extra cycle reaches the flash.
- R11: Writing configuration with bit 6 set aborts any operation at once and clears the done flag. It returns the pins to idle (CE# high) and reads back as 0.
- R12: Buffer pointer (address 5) sets a byte offset in the selected buffer. Each access to the data window (address 6) reads or writes that byte, and then advances the pointer by one.
- R13: CE# is low only while an operation is in progress. CLE and ALE are never high together, and WE# and RE# are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances pointer on data window) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dout | output | 8 | Data driven to flash |
| nf_doe | output | 1 | Output enable for nf_dout |
| nf_din | input | 8 | Data returned from flash |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions check on every cycle that the pins stay legal. CLE and ALE are exclusive, WE# and RE# are exclusive, and CE# is high when idle. They also check that the done flag rises only from a completion event, and that a page transfer never completes while the flash is busy. They check that an abort leaves the engine idle, and that the latched operation stays stable for the whole time it runs. The bench scenarios show the rest: the bytes that reach the flash model, the buffer contents after reads, the strobe count and width, spare-only sizing, where ID and status bytes land, and that a start code written mid-operation is dropped.

// File: rtl/nfe_pkg.sv
`timescale 1ns/1ps
package nfe_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_CMD, OP_ADDR, OP_DIN, OP_DOUT, OP_ID, OP_STAT
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDY_PRE, ST_LOW, ST_HIGH, ST_RDY_POST
  } st_e;

  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_ADDR = 3'd1;
  localparam logic [2:0] RA_BSEL = 3'd2;
  localparam logic [2:0] RA_CTL  = 3'd3;
  localparam logic [2:0] RA_CFG  = 3'd4;
  localparam logic [2:0] RA_PTR  = 3'd5;
  localparam logic [2:0] RA_DATA = 3'd6;

  // One-hot start code to operation; anything else starts nothing
  function automatic op_e decode_start(input logic [5:0] code);
    case (code)
      6'h01:   return OP_CMD;
      6'h02:   return OP_ADDR;
      6'h04:   return OP_DIN;
      6'h08:   return OP_DOUT;
      6'h10:   return OP_ID;
      6'h20:   return OP_STAT;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic op_reads(input op_e op);
    return (op == OP_DOUT) || (op == OP_ID) || (op == OP_STAT);
  endfunction

  function automatic logic op_is_page(input op_e op);
    return (op == OP_DOUT) || (op == OP_DIN);
  endfunction

  // Number of strobes an operation issues
  function automatic int unsigned xfer_len(input op_e op, input logic spare,
                                           input int unsigned page_n,
                                           input int unsigned spare_n,
                                           input int unsigned id_n);
    case (op)
      OP_DIN, OP_DOUT: return spare ? spare_n : page_n;
      OP_ID:           return id_n;
      default:         return 1;
    endcase
  endfunction
endpackage

// File: rtl/nfe_regs.sv
`timescale 1ns/1ps
module nfe_regs
  import nfe_pkg::*;
#(
  parameter int BUF_AW = 2,
  parameter int PTR_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              busy,
  input  logic              finish,
  input  logic [7:0]        cpu_rdata,
  output logic [7:0]        cmd_byte,
  output logic [7:0]        addr_byte,
  output logic [BUF_AW-1:0] bsel,
  output logic              cfg_spare,
  output logic              cfg_mask,
  output logic              soft_rst,
  output op_e               start_op,
  output logic [PTR_W-1:0]  cpu_ptr,
  output logic              cpu_we,
  output logic [7:0]        cpu_wdata,
  output logic              done,
  output logic              irq
);
  logic wr_ctl, data_acc;

  assign wr_ctl    = reg_we && (reg_addr == RA_CTL);
  assign soft_rst  = reg_we && (reg_addr == RA_CFG) && reg_wdata[6];
  assign data_acc  = (reg_we || reg_rd) && (reg_addr == RA_DATA);
  assign cpu_we    = reg_we && (reg_addr == RA_DATA);
  assign cpu_wdata = reg_wdata[7:0];
  assign start_op  = (wr_ctl && !busy) ? decode_start(reg_wdata[5:0]) : OP_NONE;
  assign irq       = done & ~cfg_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_byte  <= '0;
      addr_byte <= '0;
      bsel      <= '0;
      cfg_spare <= 1'b0;
      cfg_mask  <= 1'b0;
      cpu_ptr   <= '0;
      done      <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_CMD:  cmd_byte  <= reg_wdata[7:0];
          RA_ADDR: addr_byte <= reg_wdata[7:0];
          RA_BSEL: bsel      <= reg_wdata[BUF_AW-1:0];
          RA_CFG:  begin
            cfg_spare <= reg_wdata[2];
            cfg_mask  <= reg_wdata[4];
          end
          RA_PTR:  cpu_ptr   <= reg_wdata[PTR_W-1:0];
          default: ;
        endcase
      end
      if (data_acc) cpu_ptr <= cpu_ptr + 1'b1;
      if (soft_rst)                    done <= 1'b0;
      else if (finish)                 done <= 1'b1;
      else if (wr_ctl && !reg_wdata[15]) done <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CMD:  reg_rdata = {8'h00, cmd_byte};
      RA_ADDR: reg_rdata = {8'h00, addr_byte};
      RA_BSEL: reg_rdata = 16'(bsel);
      RA_CTL:  reg_rdata = {done, 15'h0000};
      RA_CFG:  reg_rdata = {11'h000, cfg_mask, 1'b0, cfg_spare, 2'b00};
      RA_PTR:  reg_rdata = 16'(cpu_ptr);
      RA_DATA: reg_rdata = {8'h00, cpu_rdata};
      default: reg_rdata = 16'h0000;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[14:7], reg_wdata[5], reg_wdata[3], reg_wdata[1:0]};
endmodule

// File: rtl/nfe_seq.sv
`timescale 1ns/1ps
module nfe_seq
  import nfe_pkg::*;
#(
  parameter int BUF_AW      = 2,
  parameter int PTR_W       = 9,
  parameter int PAGE_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ID_BYTES    = 5,
  parameter int STROBE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  op_e               start_op,
  input  logic [BUF_AW-1:0] bsel,
  input  logic              cfg_spare,
  input  logic [7:0]        cmd_byte,
  input  logic [7:0]        addr_byte,
  input  logic [7:0]        buf_rdata,
  input  logic [7:0]        nf_din,
  input  logic              nf_rb_n,
  output logic              busy,
  output logic              finish,
  output op_e               cur_op,
  output logic              page_op,
  output logic [BUF_AW-1:0] op_bsel,
  output logic [PTR_W-1:0]  eng_off,
  output logic              eng_we,
  output logic [7:0]        eng_wdata,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [7:0]        nf_dout,
  output logic              nf_doe
);
  localparam int SC_W = $clog2(STROBE_CLKS) + 1;

  st_e              st;
  logic [SC_W-1:0]  sc;
  logic [PTR_W-1:0] cnt, len_m1;
  logic             strobe_end, last_byte, is_read, in_latch;

  assign strobe_end = (sc == SC_W'(STROBE_CLKS - 1));
  assign last_byte  = (cnt == len_m1);
  assign is_read    = op_reads(cur_op);
  assign page_op    = op_is_page(cur_op);
  assign busy       = (st != ST_IDLE);
  assign in_latch   = (st == ST_LOW) || (st == ST_HIGH);
  assign finish     = !soft_rst &&
                      (((st == ST_HIGH) && strobe_end && last_byte && !page_op) ||
                       ((st == ST_RDY_POST) && nf_rb_n));

  assign eng_off   = cnt;
  assign eng_we    = (st == ST_LOW) && strobe_end && is_read && !soft_rst;
  assign eng_wdata = nf_din;

  assign nf_ce_n = !busy;
  assign nf_cle  = in_latch && (cur_op == OP_CMD);
  assign nf_ale  = in_latch && (cur_op == OP_ADDR);
  assign nf_we_n = !((st == ST_LOW) && !is_read);
  assign nf_re_n = !((st == ST_LOW) && is_read);
  assign nf_doe  = busy && !is_read;

  always_comb begin
    case (cur_op)
      OP_CMD:  nf_dout = cmd_byte;
      OP_ADDR: nf_dout = addr_byte;
      default: nf_dout = buf_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur_op  <= OP_NONE;
      op_bsel <= '0;
      len_m1  <= '0;
      cnt     <= '0;
      sc      <= '0;
    end else if (soft_rst) begin
      st     <= ST_IDLE;
      cur_op <= OP_NONE;
      cnt    <= '0;
      sc     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_op != OP_NONE) begin
          cur_op  <= start_op;
          op_bsel <= bsel;
          len_m1  <= PTR_W'(xfer_len(start_op, cfg_spare, PAGE_BYTES,
                                     SPARE_BYTES, ID_BYTES) - 1);
          cnt     <= '0;
          sc      <= '0;
          st      <= op_is_page(start_op) ? ST_RDY_PRE : ST_LOW;
        end
        ST_RDY_PRE: if (nf_rb_n) st <= ST_LOW;
        ST_LOW: begin
          if (strobe_end) begin
            sc <= '0;
            st <= ST_HIGH;
          end else sc <= sc + 1'b1;
        end
        ST_HIGH: begin
          if (strobe_end) begin
            sc <= '0;
            if (last_byte) st <= page_op ? ST_RDY_POST : ST_IDLE;
            else begin
              cnt <= cnt + 1'b1;
              st  <= ST_LOW;
            end
          end else sc <= sc + 1'b1;
        end
        ST_RDY_POST: if (nf_rb_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nfe_bufmem.sv
`timescale 1ns/1ps
module nfe_bufmem #(
  parameter int BUF_COUNT  = 4,
  parameter int PAGE_BYTES = 512,
  parameter int BUF_AW     = 2,
  parameter int PTR_W      = 9
) (
  input  logic              clk,
  input  logic [BUF_AW-1:0] e_bsel,
  input  logic [PTR_W-1:0]  e_off,
  input  logic              e_we,
  input  logic [7:0]        e_wdata,
  output logic [7:0]        e_rdata,
  input  logic [BUF_AW-1:0] c_bsel,
  input  logic [PTR_W-1:0]  c_off,
  input  logic              c_we,
  input  logic [7:0]        c_wdata,
  output logic [7:0]        c_rdata
);
  localparam int DEPTH = BUF_COUNT * PAGE_BYTES;
  localparam int IDX_W = BUF_AW + PTR_W;

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] e_idx, c_idx;

  assign e_idx   = {e_bsel, e_off};
  assign c_idx   = {c_bsel, c_off};
  assign e_rdata = mem[e_idx];
  assign c_rdata = mem[c_idx];

  // Engine capture wins over a software write to the same byte
  always_ff @(posedge clk) begin
    if (e_we) mem[e_idx] <= e_wdata;
    if (c_we && !(e_we && (e_idx == c_idx))) mem[c_idx] <= c_wdata;
  end
endmodule

// File: rtl/nand_op_engine.sv
`timescale 1ns/1ps
module nand_op_engine
  import nfe_pkg::*;
#(
  parameter int BUF_COUNT   = 4,
  parameter int PAGE_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ID_BYTES    = 5,
  parameter int STROBE_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dout,
  output logic        nf_doe,
  input  logic [7:0]  nf_din,
  input  logic        nf_rb_n
);
  localparam int BUF_AW = (BUF_COUNT > 1) ? $clog2(BUF_COUNT) : 1;
  localparam int PTR_W  = $clog2(PAGE_BYTES);

  logic              busy, finish, done, soft_rst, cfg_spare, cfg_mask, page_op;
  op_e               start_op, cur_op;
  logic [7:0]        cmd_byte, addr_byte, cpu_rdata, cpu_wdata, buf_rdata, eng_wdata;
  logic [BUF_AW-1:0] bsel, op_bsel;
  logic [PTR_W-1:0]  cpu_ptr, eng_off;
  logic              cpu_we, eng_we;

  nfe_regs #(.BUF_AW(BUF_AW), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .finish(finish), .cpu_rdata(cpu_rdata),
    .cmd_byte(cmd_byte), .addr_byte(addr_byte), .bsel(bsel),
    .cfg_spare(cfg_spare), .cfg_mask(cfg_mask), .soft_rst(soft_rst),
    .start_op(start_op), .cpu_ptr(cpu_ptr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .done(done), .irq(irq)
  );

  nfe_seq #(
    .BUF_AW(BUF_AW), .PTR_W(PTR_W), .PAGE_BYTES(PAGE_BYTES),
    .SPARE_BYTES(SPARE_BYTES), .ID_BYTES(ID_BYTES), .STROBE_CLKS(STROBE_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start_op(start_op),
    .bsel(bsel), .cfg_spare(cfg_spare), .cmd_byte(cmd_byte),
    .addr_byte(addr_byte), .buf_rdata(buf_rdata), .nf_din(nf_din),
    .nf_rb_n(nf_rb_n), .busy(busy), .finish(finish), .cur_op(cur_op),
    .page_op(page_op), .op_bsel(op_bsel), .eng_off(eng_off), .eng_we(eng_we),
    .eng_wdata(eng_wdata), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dout(nf_dout), .nf_doe(nf_doe)
  );

  nfe_bufmem #(
    .BUF_COUNT(BUF_COUNT), .PAGE_BYTES(PAGE_BYTES),
    .BUF_AW(BUF_AW), .PTR_W(PTR_W)
  ) u_mem (
    .clk(clk), .e_bsel(op_bsel), .e_off(eng_off), .e_we(eng_we),
    .e_wdata(eng_wdata), .e_rdata(buf_rdata), .c_bsel(bsel),
    .c_off(cpu_ptr), .c_we(cpu_we), .c_wdata(cpu_wdata), .c_rdata(cpu_rdata)
  );
endmodule

// File: rtl/nand_op_engine_chk.sv
`timescale 1ns/1ps
module nand_op_engine_chk
  import nfe_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic nf_ce_n,
  input logic nf_cle,
  input logic nf_ale,
  input logic nf_we_n,
  input logic nf_re_n,
  input logic nf_rb_n,
  input logic irq,
  input logic busy,
  input logic finish,
  input logic done,
  input logic soft_rst,
  input logic page_op,
  input logic cfg_mask,
  input op_e  cur_op
);
  // R2: done only rises after a completion event
  assert_done_from_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(finish));

  // R3: interrupt rises only on completion or on unmasking
  assert_irq_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(finish) || $fell(cfg_mask)));

  // R7: page transfers never complete while the flash is busy
  assert_page_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && page_op) |-> nf_rb_n);

  // R10: the running operation stays latched
  assert_op_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_op));

  // R11: abort leaves the engine idle with done clear
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (!busy && !done && nf_ce_n));

  // R13: latch enables exclusive, strobes exclusive, idle pins quiet
  assert_latch_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nf_cle, nf_ale}) && (nf_we_n || nf_re_n));
  assert_idle_pins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale));
endmodule

bind nand_op_engine nand_op_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
  .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_rb_n(nf_rb_n),
  .irq(irq), .busy(busy), .finish(finish), .done(done),
  .soft_rst(soft_rst), .page_op(page_op), .cfg_mask(cfg_mask), .cur_op(cur_op)
);

// File: tb/nand_op_engine_test.sv
`timescale 1ns/1ps
module nand_op_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_doe;
  logic [7:0]  nf_dout, nf_din;
  logic        nf_rb_n = 1'b1;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  nand_op_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dout(nf_dout),
    .nf_doe(nf_doe), .nf_din(nf_din), .nf_rb_n(nf_rb_n)
  );

  // ---------------- flash model ----------------
  int         rd_idx = 0, re_cnt = 0, cle_cnt = 0, ale_cnt = 0, prog_idx = 0;
  logic [7:0] last_cmd = 0, last_addr = 0;
  logic [7:0] prog [512];
  bit         busy_after_prog = 0;
  realtime    we_fall = 0, we_low_ns = 0;

  function automatic logic [7:0] flash_byte(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  assign nf_din = flash_byte(rd_idx);

  always @(negedge nf_we_n) we_fall = $realtime;
  always @(posedge nf_we_n) begin
    we_low_ns = $realtime - we_fall;
    if (nf_cle) begin
      last_cmd = nf_dout; cle_cnt++; rd_idx = 0; prog_idx = 0;
    end else if (nf_ale) begin
      last_addr = nf_dout; ale_cnt++;
    end else begin
      if (prog_idx < 512) prog[prog_idx] = nf_dout;
      prog_idx++;
      if (prog_idx == 512 && busy_after_prog) nf_rb_n = 1'b0;
    end
  end
  always @(posedge nf_re_n) begin rd_idx++; re_cnt++; end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    logic [15:0] v;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd3, v);
      if (v[15]) begin ok = 1; break; end
    end
  endtask

  task automatic run_op(input logic [15:0] code, output bit ok);
    wr(3'd3, code);
    wait_done(ok);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] dinbuf [512];
  logic [15:0] v;
  bit ok;
  int errs, c0;

  initial begin
    #(150000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    idle(3); rst_n = 1'b1; idle(2);
    rd_idx = 0; re_cnt = 0; cle_cnt = 0; ale_cnt = 0; prog_idx = 0;

    // Reset state
    rd(3'd3, v);
    check(v == 16'h0 && !irq, "R2 reset opctl", v, 0);
    check(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale, "R13 reset pins",
          {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 5'b11100);

    // R4 command cycle, R2 start bits zero while busy, R3 irq
    wr(3'd0, 16'h0070);
    wr(3'd3, 16'h0001);
    #1 check(!nf_ce_n, "R13 ce low while busy", nf_ce_n, 0);
    rd(3'd3, v);
    check(v == 16'h0, "R2 start bits read zero", v, 0);
    wait_done(ok);
    check(ok && last_cmd == 8'h70 && cle_cnt == 1, "R4 command cycle", last_cmd, 8'h70);
    check(we_low_ns > 9.9 && we_low_ns < 10.1, "R4 strobe width ns", int'(we_low_ns), 10);
    check(irq, "R3 irq on done", irq, 1);
    #1 check(nf_ce_n, "R13 ce high after op", nf_ce_n, 1);

    wr(3'd1, 16'h00C3);
    run_op(16'h0002, ok);
    check(ok && last_addr == 8'hC3 && ale_cnt == 1, "R4 address cycle", last_addr, 8'hC3);

    // R2 clear by write with bit15 clear
    wr(3'd3, 16'h0000); rd(3'd3, v);
    check(v[15] == 1'b0 && !irq, "R2 done cleared", v, 0);

    // R3 mask
    wr(3'd4, 16'h0010);
    run_op(16'h0001, ok);
    check(ok && !irq, "R3 masked irq", irq, 0);
    wr(3'd4, 16'h0000);
    #1 check(irq, "R3 irq after unmask", irq, 1);
    wr(3'd3, 16'h0000);

    // R1 non-one-hot code ignored
    c0 = cle_cnt + ale_cnt;
    wr(3'd3, 16'h0003); idle(20); rd(3'd3, v);
    check(v == 0 && cle_cnt + ale_cnt == c0 && nf_ce_n, "R1 bad code ignored", v, 0);

    // R12 buffer window on buffer 1
    wr(3'd2, 16'd1); wr(3'd5, 16'd0);
    for (int i = 0; i < 512; i++) begin
      dinbuf[i] = 8'($urandom);
      wr(3'd6, {8'h00, dinbuf[i]});
    end
    wr(3'd5, 16'd7); rd(3'd6, v); rd(3'd6, v); rd(3'd5, v);
    check(v == 16'd9, "R12 pointer advance", v, 9);
    wr(3'd5, 16'd7); rd(3'd6, v);
    check(v[7:0] == dinbuf[7], "R12 window read", v[7:0], dinbuf[7]);

    // R6 + R7 data input, flash goes busy after last byte
    wr(3'd0, 16'h0080); run_op(16'h0001, ok);
    busy_after_prog = 1;
    wr(3'd3, 16'h0004);
    for (int i = 0; i < 3000 && prog_idx < 512; i++) @(negedge clk);
    idle(40); rd(3'd3, v);
    check(v[15] == 0 && !nf_rb_n, "R7 done held while busy after input", v, 0);
    busy_after_prog = 0; nf_rb_n = 1'b1;
    wait_done(ok);
    errs = 0;
    for (int i = 0; i < 512; i++) if (prog[i] !== dinbuf[i]) errs++;
    check(ok && prog_idx == 512 && errs == 0, "R6 input bytes", errs, 0);

    // R5 + R7 data output into buffer 2, busy at start
    wr(3'd0, 16'h0000); run_op(16'h0001, ok);
    wr(3'd2, 16'd2);
    nf_rb_n = 1'b0; re_cnt = 0;
    wr(3'd3, 16'h0008); idle(50);
    check(re_cnt == 0 && !nf_ce_n, "R7 no strobe while busy", re_cnt, 0);
    nf_rb_n = 1'b1;
    wait_done(ok);
    check(ok && re_cnt == 512, "R5 strobe count", re_cnt, 512);
    wr(3'd5, 16'd0); errs = 0;
    for (int i = 0; i < 512; i++) begin
      rd(3'd6, v);
      if (v[7:0] != flash_byte(i)) errs++;
    end
    check(errs == 0, "R5 output bytes", errs, 0);

    // R9 ID read into buffer 3
    wr(3'd2, 16'd3); wr(3'd5, 16'd5); wr(3'd6, 16'h00A5);
    wr(3'd0, 16'h0090); run_op(16'h0001, ok);
    run_op(16'h0010, ok);
    wr(3'd5, 16'd0); errs = 0;
    for (int i = 0; i < 5; i++) begin
      rd(3'd6, v);
      if (v[7:0] != flash_byte(i)) errs++;
    end
    rd(3'd6, v);
    check(ok && errs == 0 && v[7:0] == 8'hA5, "R9 ID bytes", errs, 0);

    // R9 status read into buffer 1
    wr(3'd2, 16'd1);
    run_op(16'h0001, ok);
    run_op(16'h0020, ok);
    wr(3'd5, 16'd0); rd(3'd6, v);
    check(ok && v[7:0] == flash_byte(0), "R9 status byte", v[7:0], flash_byte(0));
    rd(3'd6, v);
    check(v[7:0] == dinbuf[1], "R9 neighbour kept", v[7:0], dinbuf[1]);

    // R8 spare-only output
    wr(3'd4, 16'h0004);
    run_op(16'h0001, ok);
    run_op(16'h0008, ok);
    check(ok && rd_idx == 16, "R8 spare strobes", rd_idx, 16);
    wr(3'd5, 16'd16); rd(3'd6, v);
    check(v[7:0] == dinbuf[16], "R8 byte 16 untouched", v[7:0], dinbuf[16]);
    wr(3'd4, 16'h0000);

    // R10 start ignored while busy
    run_op(16'h0001, ok);
    c0 = cle_cnt; nf_rb_n = 1'b0;
    wr(3'd3, 16'h0008); idle(5);
    wr(3'd3, 16'h0001); idle(5);
    nf_rb_n = 1'b1;
    wait_done(ok); idle(20);
    check(ok && cle_cnt == c0 && rd_idx == 512, "R10 second start ignored", cle_cnt, c0);

    // R11 soft reset mid-operation
    nf_rb_n = 1'b0; re_cnt = 0;
    wr(3'd3, 16'h0008); idle(5);
    wr(3'd4, 16'h0040);
    #1 check(nf_ce_n, "R11 pins idle after abort", nf_ce_n, 1);
    nf_rb_n = 1'b1; idle(30);
    rd(3'd3, v);
    check(v[15] == 0 && re_cnt == 0, "R11 aborted op", re_cnt, 0);
    rd(3'd4, v);
    check(v[6] == 0, "R11 bit self-clears", v, 0);

    // R4 random command/address cycles
    errs = 0;
    for (int i = 0; i < 24; i++) begin
      logic [7:0] b;
      bit is_cmd;
      b = 8'($urandom); is_cmd = 1'($urandom);
      wr(is_cmd ? 3'd0 : 3'd1, {8'h00, b});
      run_op(is_cmd ? 16'h0001 : 16'h0002, ok);
      if (!ok || (is_cmd ? last_cmd : last_addr) != b) errs++;
    end
    check(errs == 0, "R4 random latch cycles", errs, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule